// File: doc/BRIEF.md
# Dual-Port RAM with Mailbox Interrupts

This block is a synchronous true dual-port byte memory with two fully independent ports, called left and right. Each port has an active-low select, a write strobe, an address, write data and registered read data, so both sides can read or write any location at any time. The default address width is 11 bits (2048 bytes) so the default elaboration stays small. Setting `ADDR_W` to 13 gives the full 8K x 8 array.

The two highest addresses serve as mailboxes. Each port owns one incoming mailbox and one active-low interrupt output. When the opposite port writes to that mailbox, the owning port's interrupt is raised. The interrupt is withdrawn when the owning port reads its mailbox. The byte stored in a mailbox is ordinary user data.

A static configuration input, `mbox_en`, switches the mailbox function off. While it is low, both top addresses behave as plain memory and neither interrupt asserts. Typical use is one processor per side: the sender writes a message word into the partner's mailbox, and the receiver services the interrupt by reading that word.

Top module: `dpm_mailbox`

## Requirements
- R1: Either port can write any address. A read of an address on either port returns the stored byte on that port's read data one clock after the read is presented. A byte written by one port can be read back by the other port.
- R2: The left incoming mailbox is address all-ones minus one (0x7FE by default, 0x1FFE with a 13-bit address). When the right port writes it while `mbox_en` is high, `l_irq_n` is low from the next cycle.
- R3: When the left port reads address all-ones minus one while `mbox_en` is high, `l_irq_n` returns high in the next cycle.
- R4: The right incoming mailbox is the all-ones address (0x7FF by default, 0x1FFF with a 13-bit address). When the left port writes it while `mbox_en` is high, `r_irq_n` is low from the next cycle.
- R5: When the right port reads the all-ones address while `mbox_en` is high, `r_irq_n` returns high in the next cycle. A read of the other port's mailbox leaves both interrupts unchanged.
- R6: The bytes held at both mailbox addresses are stored and returned like any other location.
- R7: A port whose select is high (inactive) performs no access. It does not write memory, does not set the partner's interrupt and does not clear its own.
- R8: A port that writes its own incoming mailbox leaves its own interrupt unchanged.
- R9: If a set and a clear of the same interrupt fall in the same cycle, the interrupt ends up set.
- R10: While `mbox_en` is low, both top addresses act as plain memory and both interrupts are high. An interrupt that was set goes high in the cycle after `mbox_en` goes low.
- R11: After reset, both interrupts are high and both read data outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Synchronous active-low reset |
| mbox_en | input | 1 | High enables the mailbox interrupts |
| l_cs_n | input | 1 | Left port select, active low |
| l_we | input | 1 | Left port write strobe (1 = write, 0 = read) |
| l_addr | input | ADDR_W | Left port address |
| l_wdata | input | DATA_W | Left port write data |
| l_rdata | output | DATA_W | Left port registered read data |
| l_irq_n | output | 1 | Left interrupt, active low |
| r_cs_n | input | 1 | Right port select, active low |
| r_we | input | 1 | Right port write strobe (1 = write, 0 = read) |
| r_addr | input | ADDR_W | Right port address |
| r_wdata | input | DATA_W | Right port write data |
| r_rdata | output | DATA_W | Right port registered read data |
| r_irq_n | output | 1 | Right interrupt, active low |

## Verification
Two functions can land on one flag in the same clock: a set, caused by the partner writing the mailbox, and a clear, caused by the owner reading it. The bench provokes this by having the right port write the left mailbox while the left port reads that same address in one cycle. It then expects `l_irq_n` to stay low, and a later read by the left port to return the new byte and release the flag. A self-write, a deselected access and a disabled mailbox function are each placed next to a pending flag, so the bench can see whether the flag moves when it should not.

// File: rtl/dpm_pkg.sv
// Shared definitions for the dual-port mailbox memory.
// Assumes select is active low and the write strobe is active high.
package dpm_pkg;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_e;

    // Classify one port's request in the current cycle.
    function automatic acc_e acc_kind(input logic cs_n, input logic we);
        if (cs_n)    return ACC_IDLE;
        else if (we) return ACC_WRITE;
        else         return ACC_READ;
    endfunction

endpackage

// File: rtl/dpm_port_decode.sv
// Decodes one port's request into memory strobes and mailbox hits.
// IN_MB is the mailbox this port receives on; OUT_MB is the mailbox
// it sends to. Assumes both are distinct addresses of the array.
module dpm_port_decode #(
    parameter int ADDR_W = 11,
    parameter logic [ADDR_W-1:0] IN_MB  = '0,
    parameter logic [ADDR_W-1:0] OUT_MB = '0
) (
    input  logic              cs_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    output logic              mem_wr,
    output logic              mem_rd,
    output logic              rd_in_mb,
    output logic              wr_out_mb
);
    import dpm_pkg::*;

    acc_e kind;

    // Turn select and strobe into an access kind, then into hits.
    always_comb begin
        kind      = acc_kind(cs_n, we);
        mem_wr    = (kind == ACC_WRITE);
        mem_rd    = (kind == ACC_READ);
        rd_in_mb  = mem_rd && (addr == IN_MB);
        wr_out_mb = mem_wr && (addr == OUT_MB);
    end

endmodule

// File: rtl/dpm_ram_core.sv
// True dual-port synchronous RAM with registered read data.
// Read-first on a cross-port collision; if both ports write one
// address in one cycle, port B's data is kept. Memory is not reset.
module dpm_ram_core #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_wr,
    input  logic              a_rd,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_rdata,
    input  logic              b_wr,
    input  logic              b_rd,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] b_rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Commit the writes of both ports.
    always_ff @(posedge clk) begin
        if (a_wr) mem[a_addr] <= a_wdata;
        if (b_wr) mem[b_addr] <= b_wdata;
    end

    // Register the read data of both ports; hold it when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_rdata <= '0;
            b_rdata <= '0;
        end else begin
            if (a_rd) a_rdata <= mem[a_addr];
            if (b_rd) b_rdata <= mem[b_addr];
        end
    end

endmodule

// File: rtl/dpm_irq_flag.sv
// One mailbox interrupt flag. A set wins over a clear in the same
// cycle, and a low enable forces the flag inactive.
module dpm_irq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic set,
    input  logic clr,
    output logic irq_n
);
    logic flag_q;

    // Update the pending state from the set and clear events.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) flag_q <= 1'b0;
        else if (set)          flag_q <= 1'b1;
        else if (clr)          flag_q <= 1'b0;
    end

    assign irq_n = ~flag_q;

endmodule

// File: rtl/dpm_mailbox.sv
// Dual-port RAM with two mailbox interrupts at the top two addresses.
// Index 0 is the left port and index 1 is the right port. The left
// mailbox is all-ones minus one and the right mailbox is all-ones.
module dpm_mailbox #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mbox_en,
    input  logic              l_cs_n,
    input  logic              l_we,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    output logic              l_irq_n,
    input  logic              r_cs_n,
    input  logic              r_we,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata,
    output logic              r_irq_n
);
    localparam int NPORT = 2;
    localparam logic [ADDR_W-1:0] MB_RIGHT = '1;
    localparam logic [ADDR_W-1:0] MB_LEFT  = MB_RIGHT - 1'b1;

    logic              cs_n_a [NPORT];
    logic              we_a   [NPORT];
    logic [ADDR_W-1:0] addr_a [NPORT];
    logic              mem_wr [NPORT];
    logic              mem_rd [NPORT];
    logic              rd_in  [NPORT];
    logic              wr_out [NPORT];
    logic              irq_a  [NPORT];

    assign cs_n_a[0] = l_cs_n;
    assign cs_n_a[1] = r_cs_n;
    assign we_a[0]   = l_we;
    assign we_a[1]   = r_we;
    assign addr_a[0] = l_addr;
    assign addr_a[1] = r_addr;

    for (genvar g = 0; g < NPORT; g++) begin : g_port
        localparam logic [ADDR_W-1:0] IN_MB  = (g == 0) ? MB_LEFT : MB_RIGHT;
        localparam logic [ADDR_W-1:0] OUT_MB = (g == 0) ? MB_RIGHT : MB_LEFT;

        dpm_port_decode #(
            .ADDR_W (ADDR_W),
            .IN_MB  (IN_MB),
            .OUT_MB (OUT_MB)
        ) u_dec (
            .cs_n      (cs_n_a[g]),
            .we        (we_a[g]),
            .addr      (addr_a[g]),
            .mem_wr    (mem_wr[g]),
            .mem_rd    (mem_rd[g]),
            .rd_in_mb  (rd_in[g]),
            .wr_out_mb (wr_out[g])
        );

        dpm_irq_flag u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .enable (mbox_en),
            .set    (wr_out[NPORT-1-g]),
            .clr    (rd_in[g]),
            .irq_n  (irq_a[g])
        );
    end

    assign l_irq_n = irq_a[0];
    assign r_irq_n = irq_a[1];

    dpm_ram_core #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_ram (
        .clk     (clk),
        .rst_n   (rst_n),
        .a_wr    (mem_wr[0]),
        .a_rd    (mem_rd[0]),
        .a_addr  (l_addr),
        .a_wdata (l_wdata),
        .a_rdata (l_rdata),
        .b_wr    (mem_wr[1]),
        .b_rd    (mem_rd[1]),
        .b_addr  (r_addr),
        .b_wdata (r_wdata),
        .b_rdata (r_rdata)
    );

endmodule

// File: rtl/dpm_mailbox_chk.sv
// Checker for the mailbox interrupt behaviour, observed at the ports.
module dpm_mailbox_chk #(
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mbox_en,
    input logic              l_cs_n,
    input logic              l_we,
    input logic [ADDR_W-1:0] l_addr,
    input logic              l_irq_n,
    input logic              r_cs_n,
    input logic              r_we,
    input logic [ADDR_W-1:0] r_addr,
    input logic              r_irq_n
);
    localparam logic [ADDR_W-1:0] MBR = '1;
    localparam logic [ADDR_W-1:0] MBL = MBR - 1'b1;

    logic r_wr_mbl, l_wr_mbr;
    assign r_wr_mbl = !r_cs_n && r_we && (r_addr == MBL);
    assign l_wr_mbr = !l_cs_n && l_we && (l_addr == MBR);

    // R2
    l_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mbox_en && r_wr_mbl) |=> !l_irq_n);
    // R4
    r_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mbox_en && l_wr_mbr) |=> !r_irq_n);
    // R3
    l_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mbox_en && !l_cs_n && !l_we && l_addr == MBL && !r_wr_mbl) |=> l_irq_n);
    // R5
    r_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mbox_en && !r_cs_n && !r_we && r_addr == MBR && !l_wr_mbr) |=> r_irq_n);
    // R8
    l_own_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mbox_en && !l_cs_n && l_we && !r_wr_mbl) |=> $stable(l_irq_n));
    // R8
    r_own_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mbox_en && !r_cs_n && r_we && !l_wr_mbr) |=> $stable(r_irq_n));
    // R7
    l_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mbox_en && l_cs_n && !r_wr_mbl) |=> $stable(l_irq_n));
    // R10
    l_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mbox_en |=> l_irq_n);
    // R10
    r_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mbox_en |=> r_irq_n);

endmodule

bind dpm_mailbox dpm_mailbox_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .mbox_en (mbox_en),
    .l_cs_n  (l_cs_n),
    .l_we    (l_we),
    .l_addr  (l_addr),
    .l_irq_n (l_irq_n),
    .r_cs_n  (r_cs_n),
    .r_we    (r_we),
    .r_addr  (r_addr),
    .r_irq_n (r_irq_n)
);

// File: tb/tb_dpm_mailbox.sv
module tb_dpm_mailbox;
    localparam int AW = 11;
    localparam int DW = 8;
    localparam int NV = 17;

    typedef struct packed {
        logic          l_cs_n;
        logic          l_we;
        logic [AW-1:0] l_addr;
        logic [DW-1:0] l_wd;
        logic          r_cs_n;
        logic          r_we;
        logic [AW-1:0] r_addr;
        logic [DW-1:0] r_wd;
        logic          e_l_irq_n;
        logic          e_r_irq_n;
        logic          chk_l;
        logic [DW-1:0] e_l_rd;
        logic          chk_r;
        logic [DW-1:0] e_r_rd;
    } vec_t;

    // Mailboxes: left 0x7FE, right 0x7FF. Idle port: cs_n=1.
    localparam vec_t VEC [NV] = '{
        {1'b0,1'b1,11'h010,8'hA5, 1'b0,1'b1,11'h020,8'h3C, 1'b1,1'b1, 1'b0,8'h00, 1'b0,8'h00}, // R1 writes
        {1'b0,1'b0,11'h020,8'h00, 1'b0,1'b0,11'h010,8'h00, 1'b1,1'b1, 1'b1,8'h3C, 1'b1,8'hA5}, // R1 cross reads
        {1'b1,1'b0,11'h000,8'h00, 1'b1,1'b1,11'h010,8'hFF, 1'b1,1'b1, 1'b0,8'h00, 1'b0,8'h00}, // R7 deselected write
        {1'b0,1'b0,11'h010,8'h00, 1'b1,1'b0,11'h000,8'h00, 1'b1,1'b1, 1'b1,8'hA5, 1'b0,8'h00}, // R7 data kept
        {1'b1,1'b0,11'h000,8'h00, 1'b0,1'b1,11'h7FE,8'h55, 1'b0,1'b1, 1'b0,8'h00, 1'b0,8'h00}, // R2 set left
        {1'b0,1'b1,11'h7FF,8'h66, 1'b1,1'b0,11'h000,8'h00, 1'b0,1'b0, 1'b0,8'h00, 1'b0,8'h00}, // R4 set right
        {1'b0,1'b0,11'h7FE,8'h00, 1'b1,1'b0,11'h000,8'h00, 1'b1,1'b0, 1'b1,8'h55, 1'b0,8'h00}, // R3 R6 clear left
        {1'b1,1'b0,11'h000,8'h00, 1'b0,1'b0,11'h7FE,8'h00, 1'b1,1'b0, 1'b0,8'h00, 1'b1,8'h55}, // R5 foreign read
        {1'b1,1'b0,11'h000,8'h00, 1'b0,1'b0,11'h7FF,8'h00, 1'b1,1'b1, 1'b0,8'h00, 1'b1,8'h66}, // R5 R6 clear right
        {1'b0,1'b1,11'h7FE,8'h77, 1'b1,1'b0,11'h000,8'h00, 1'b1,1'b1, 1'b0,8'h00, 1'b0,8'h00}, // R8 self write
        {1'b1,1'b0,11'h000,8'h00, 1'b0,1'b1,11'h7FE,8'h11, 1'b0,1'b1, 1'b0,8'h00, 1'b0,8'h00}, // R2 set left
        {1'b0,1'b1,11'h7FE,8'h22, 1'b1,1'b0,11'h000,8'h00, 1'b0,1'b1, 1'b0,8'h00, 1'b0,8'h00}, // R8 self write held
        {1'b1,1'b0,11'h7FE,8'h00, 1'b1,1'b0,11'h000,8'h00, 1'b0,1'b1, 1'b0,8'h00, 1'b0,8'h00}, // R7 deselected read
        {1'b0,1'b0,11'h7FE,8'h00, 1'b0,1'b1,11'h7FE,8'h99, 1'b0,1'b1, 1'b0,8'h00, 1'b0,8'h00}, // R9 set wins
        {1'b0,1'b0,11'h7FE,8'h00, 1'b1,1'b0,11'h000,8'h00, 1'b1,1'b1, 1'b1,8'h99, 1'b0,8'h00}, // R3 R6 clear
        {1'b1,1'b0,11'h000,8'h00, 1'b0,1'b1,11'h7FF,8'h44, 1'b1,1'b1, 1'b0,8'h00, 1'b0,8'h00}, // R8 right self
        {1'b1,1'b0,11'h000,8'h00, 1'b0,1'b0,11'h7FF,8'h00, 1'b1,1'b1, 1'b0,8'h00, 1'b1,8'h44}  // R6 readback
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mbox_en = 1'b1;
    logic          l_cs_n = 1'b1, l_we = 1'b0, r_cs_n = 1'b1, r_we = 1'b0;
    logic [AW-1:0] l_addr = '0, r_addr = '0;
    logic [DW-1:0] l_wdata = '0, r_wdata = '0;
    logic [DW-1:0] l_rdata, r_rdata;
    logic          l_irq_n, r_irq_n;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    dpm_mailbox #(.ADDR_W(AW), .DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .mbox_en(mbox_en),
        .l_cs_n(l_cs_n), .l_we(l_we), .l_addr(l_addr), .l_wdata(l_wdata),
        .l_rdata(l_rdata), .l_irq_n(l_irq_n),
        .r_cs_n(r_cs_n), .r_we(r_we), .r_addr(r_addr), .r_wdata(r_wdata),
        .r_rdata(r_rdata), .r_irq_n(r_irq_n)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive_l(input logic cs_n, input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d);
        l_cs_n = cs_n; l_we = we; l_addr = a; l_wdata = d;
    endtask

    task automatic drive_r(input logic cs_n, input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d);
        r_cs_n = cs_n; r_we = we; r_addr = a; r_wdata = d;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        @(negedge clk);
        step();
        step();
        rst_n = 1'b1;
        // R11 reset state
        check("R11 l_irq_n", l_irq_n, 1);
        check("R11 r_irq_n", r_irq_n, 1);
        check("R11 l_rdata", l_rdata, 0);
        check("R11 r_rdata", r_rdata, 0);

        for (int i = 0; i < NV; i++) begin
            drive_l(VEC[i].l_cs_n, VEC[i].l_we, VEC[i].l_addr, VEC[i].l_wd);
            drive_r(VEC[i].r_cs_n, VEC[i].r_we, VEC[i].r_addr, VEC[i].r_wd);
            step();
            check($sformatf("R2 R3 vec%0d l_irq_n", i), l_irq_n, VEC[i].e_l_irq_n);
            check($sformatf("R4 R5 vec%0d r_irq_n", i), r_irq_n, VEC[i].e_r_irq_n);
            if (VEC[i].chk_l) check($sformatf("R1 R6 vec%0d l_rdata", i), l_rdata, VEC[i].e_l_rd);
            if (VEC[i].chk_r) check($sformatf("R1 R6 vec%0d r_rdata", i), r_rdata, VEC[i].e_r_rd);
        end

        // R10: disabling clears a pending flag
        drive_l(1, 0, 0, 0);
        drive_r(0, 1, 11'h7FE, 8'h5A);
        step();
        check("R10 armed l_irq_n", l_irq_n, 0);
        drive_r(1, 0, 0, 0);
        mbox_en = 1'b0;
        step();
        check("R10 cleared l_irq_n", l_irq_n, 1);
        // R10: mailbox addresses are plain memory while disabled
        drive_l(0, 1, 11'h7FF, 8'hCD);
        drive_r(0, 1, 11'h7FE, 8'hAB);
        step();
        check("R10 off l_irq_n", l_irq_n, 1);
        check("R10 off r_irq_n", r_irq_n, 1);
        drive_l(0, 0, 11'h7FE, 0);
        drive_r(0, 0, 11'h7FF, 0);
        step();
        check("R10 l_rdata", l_rdata, 8'hAB);
        check("R10 r_rdata", r_rdata, 8'hCD);
        check("R10 read l_irq_n", l_irq_n, 1);
        check("R10 read r_irq_n", r_irq_n, 1);

        // R11: reset withdraws pending flags and zeroes read data
        mbox_en = 1'b1;
        drive_l(0, 1, 11'h7FF, 8'h01);
        drive_r(0, 1, 11'h7FE, 8'h02);
        step();
        check("R11 pre l_irq_n", l_irq_n, 0);
        check("R11 pre r_irq_n", r_irq_n, 0);
        drive_l(1, 0, 0, 0);
        drive_r(1, 0, 0, 0);
        rst_n = 1'b0;
        step();
        check("R11 mid l_irq_n", l_irq_n, 1);
        check("R11 mid r_irq_n", r_irq_n, 1);
        check("R11 mid l_rdata", l_rdata, 0);
        rst_n = 1'b1;
        step();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule